// File: doc/BRIEF.md
# Cascadable Magnitude Comparator

This block compares two unsigned 8-bit operands, A and B, and reports how they relate: equal, A greater than B, A greater than or equal to B, and B greater than or equal to A. It has no clock and no state; every output follows the current inputs through logic alone.

An equality input from a neighbouring stage lets several units be chained to compare wider words. The equal result is qualified by that input and is driven in both active-high and active-low form. The strict greater-than result reflects only the local operands. With the equality input tied high, a unit acts as a standalone 8-bit comparator.

Top module: `mag_cmp_cascade`

## Requirements
- R1: Operands are unsigned, with bit 0 the least significant bit. a_gt_b_o is 1 exactly when A > B.
- R2: eq_o is 1 exactly when A == B and eq_in_i is 1.
- R3: eq_no is always the exact complement of eq_o.
- R4: eq_in_i has no effect on a_gt_b_o.
- R5: a_ge_b_o equals a_gt_b_o OR eq_o.
- R6: b_ge_a_o is 1 exactly when eq_o is 1 or A < B.
- R7: With eq_in_i at 1, the outputs match a standalone comparison for all 65536 operand pairs.
- R8: With eq_in_i at 0 and A == B, eq_o, a_ge_b_o and b_ge_a_o are 0 and eq_no is 1.
- R9: The outputs settle from the present inputs alone, with no clock and no dependence on earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Operand A, unsigned |
| b_i | input | 8 | Operand B, unsigned |
| eq_in_i | input | 1 | Equality result from the adjacent stage |
| eq_o | output | 1 | Cascaded equal, active high |
| eq_no | output | 1 | Cascaded equal, active low |
| a_gt_b_o | output | 1 | A greater than B, local only |
| a_ge_b_o | output | 1 | A greater than or equal to B |
| b_ge_a_o | output | 1 | B greater than or equal to A |

## Verification
Assertions check on every settled input change that the equal outputs are complementary, that the inclusive outputs are built from the strict and equal results, and that the cascaded equal agrees with the operands and the equality input. Whether the strict greater-than is correct as an unsigned magnitude, with bit 0 as the least significant bit, and whether it is blind to the equality input, only the bench can show, by sweeping every operand pair under both cascade values and by directed cases on the top bit and the all-ones and all-zeros boundaries.

// File: rtl/mag_cmp_pkg.sv
package mag_cmp_pkg;
  localparam int unsigned CMP_W = 8;

  typedef struct packed {
    logic eq;
    logic gt;
  } local_cmp_t;
endpackage

// File: rtl/mag_cmp_eq_unit.sv
module mag_cmp_eq_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         eq_o
);
  logic [W-1:0] bit_eq;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_eq[i] = ~(a_i[i] ^ b_i[i]);
  end

  assign eq_o = &bit_eq;
endmodule

// File: rtl/mag_cmp_gt_unit.sv
module mag_cmp_gt_unit #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         gt_o
);
  // ripple from lsb: a higher differing bit overrides everything below
  logic [W:0] gt_chain;

  assign gt_chain[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gt_chain[i+1] = (a_i[i] & ~b_i[i]) | (~(a_i[i] ^ b_i[i]) & gt_chain[i]);
  end

  assign gt_o = gt_chain[W];
endmodule

// File: rtl/mag_cmp_out_stage.sv
module mag_cmp_out_stage
  import mag_cmp_pkg::*;
(
  input  local_cmp_t loc_i,
  input  logic       eq_in_i,
  output logic       eq_o,
  output logic       eq_no,
  output logic       a_gt_b_o,
  output logic       a_ge_b_o,
  output logic       b_ge_a_o
);
  logic eq_casc;

  assign eq_casc  = loc_i.eq & eq_in_i;
  assign eq_o     = eq_casc;
  assign eq_no    = ~eq_casc;
  assign a_gt_b_o = loc_i.gt;
  assign a_ge_b_o = loc_i.gt | eq_casc;
  // a<b is neither gt nor locally equal
  assign b_ge_a_o = eq_casc | (~loc_i.gt & ~loc_i.eq);
endmodule

// File: rtl/mag_cmp_cascade.sv
module mag_cmp_cascade
  import mag_cmp_pkg::*;
#(
  parameter int unsigned W = CMP_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         eq_in_i,
  output logic         eq_o,
  output logic         eq_no,
  output logic         a_gt_b_o,
  output logic         a_ge_b_o,
  output logic         b_ge_a_o
);
  local_cmp_t loc;

  mag_cmp_eq_unit #(.W(W)) u_eq (
    .a_i (a_i),
    .b_i (b_i),
    .eq_o(loc.eq)
  );

  mag_cmp_gt_unit #(.W(W)) u_gt (
    .a_i (a_i),
    .b_i (b_i),
    .gt_o(loc.gt)
  );

  mag_cmp_out_stage u_out (
    .loc_i   (loc),
    .eq_in_i (eq_in_i),
    .eq_o    (eq_o),
    .eq_no   (eq_no),
    .a_gt_b_o(a_gt_b_o),
    .a_ge_b_o(a_ge_b_o),
    .b_ge_a_o(b_ge_a_o)
  );

  always_comb begin
    if (!$isunknown({a_i, b_i, eq_in_i, eq_o, eq_no, a_gt_b_o, a_ge_b_o, b_ge_a_o})) begin
      assert_eq_polarity_R3: assert (eq_o ^ eq_no);
      assert_eq_casc_R2: assert (eq_o == ((a_i == b_i) && eq_in_i));
      assert_age_build_R5: assert (a_ge_b_o == (a_gt_b_o | eq_o));
      assert_gt_excl_eq_R1: assert (!(a_gt_b_o && eq_o));
      assert_bge_excl_gt_R6: assert (!(b_ge_a_o && a_gt_b_o));
      assert_eq_in_low_R8: assert (eq_in_i || (!eq_o && !a_ge_b_o || a_gt_b_o));
    end
  end
endmodule

// File: tb/mag_cmp_cascade_bench.sv
`timescale 1ns/1ps
module mag_cmp_cascade_bench;
  localparam int unsigned W = 8;
  localparam int unsigned WDOG = 190000;
  localparam int unsigned NVEC = 12;

  // {a, b, eq_in, eq, gt, a_ge_b, b_ge_a}
  localparam logic [20:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 1'b1, 4'b1011},
    {8'h00, 8'h00, 1'b0, 4'b0000},
    {8'hFF, 8'hFF, 1'b1, 4'b1011},
    {8'hFF, 8'h00, 1'b1, 4'b0110},
    {8'h00, 8'hFF, 1'b0, 4'b0001},
    {8'h80, 8'h7F, 1'b1, 4'b0110},
    {8'h7F, 8'h80, 1'b1, 4'b0001},
    {8'h01, 8'h00, 1'b0, 4'b0110},
    {8'h55, 8'hAA, 1'b1, 4'b0001},
    {8'hA5, 8'hA5, 1'b0, 4'b0000},
    {8'hFE, 8'hFF, 1'b1, 4'b0001},
    {8'h81, 8'h80, 1'b0, 4'b0110}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [W-1:0] a, b;
  logic eq_in;
  logic eq, eq_n, gt, age, bge;
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mag_cmp_cascade u_mag_cmp_cascade (
    .a_i     (a),
    .b_i     (b),
    .eq_in_i (eq_in),
    .eq_o    (eq),
    .eq_no   (eq_n),
    .a_gt_b_o(gt),
    .a_ge_b_o(age),
    .b_ge_a_o(bge)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s a=%02h b=%02h eq_in=%0b act=%0b exp=%0b", tag, a, b, eq_in, act, exp);
    end
  endtask

  task automatic apply_check(input logic [W-1:0] av, input logic [W-1:0] bv, input logic ei);
    int ua, ub;
    a = av; b = bv; eq_in = ei;
    #1;
    ua = int'(av); ub = int'(bv);
    chk("R1 gt", gt, ua > ub);
    chk("R2 eq", eq, (ua == ub) && ei);
    chk("R3 eq_n", eq_n, !((ua == ub) && ei));
    chk("R5 a_ge_b", age, (ua > ub) || ((ua == ub) && ei));
    chk("R6 b_ge_a", bge, (ua < ub) || ((ua == ub) && ei));
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc >= WDOG && !done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired act=%0d exp<%0d", cyc, WDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; eq_in = 1'b1;
    #3 rst_ni = 1'b1;
    // idle state with zero operands
    #1;
    chk("R2 idle eq", eq, 1'b1);
    chk("R1 idle gt", gt, 1'b0);

    for (int k = 0; k < NVEC; k++) begin
      a = VEC[k][20:13]; b = VEC[k][12:5]; eq_in = VEC[k][4];
      #1;
      chk("R2 vec eq", eq, VEC[k][3]);
      chk("R3 vec eq_n", eq_n, ~VEC[k][3]);
      chk("R1 vec gt", gt, VEC[k][2]);
      chk("R5 vec a_ge_b", age, VEC[k][1]);
      chk("R6 vec b_ge_a", bge, VEC[k][0]);
    end

    // R7 standalone sweep, eq_in high
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        apply_check(i[W-1:0], j[W-1:0], 1'b1);

    // R4 eq_in toggling leaves gt unchanged
    for (int i = 0; i < 256; i++) begin
      logic g1;
      a = i[W-1:0]; b = 8'h80 - 8'(i % 3);
      eq_in = 1'b1; #1; g1 = gt;
      eq_in = 1'b0; #1;
      chk("R4 gt vs eq_in", gt, g1);
    end

    // R8 eq_in low with equal operands
    for (int i = 0; i < 256; i++) begin
      apply_check(i[W-1:0], i[W-1:0], 1'b0);
      chk("R8 eq low", eq, 1'b0);
      chk("R8 age low", age, 1'b0);
      chk("R8 bge low", bge, 1'b0);
      chk("R8 eq_n high", eq_n, 1'b1);
    end

    // R9 no history: revisit a pair after differing stimulus
    apply_check(8'h3C, 8'h3C, 1'b1);
    apply_check(8'hC3, 8'h3C, 1'b0);
    apply_check(8'h3C, 8'h3C, 1'b1);
    chk("R9 eq back", eq, 1'b1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule